// File: doc/BRIEF.md
# Multi-CPU Masked Interrupt Router

This block gathers level-sensitive device interrupt requests into one raw request register and hands them out to several processors. Each processor owns a mask register of the same width as the raw register; the processor's hard-interrupt output is raised whenever any request it has unmasked is active. A cascaded legacy interrupt controller has its own input pin, which is folded onto one fixed raw line.

Software reaches the block through a simple register port with separate read and write strobes. It may write the masks and read back the masks, the raw register and a per-processor view of the masked requests. Processor slots that are configured as absent keep their output low whatever their mask holds. An access to an offset the block does not decode returns all ones and raises an error pulse.

Top module: `irq_router`

## Requirements
- R1: One clock edge after the request inputs change, the raw register (read at offset 0x300) equals the request input vector.
- R2: The cascade input is ORed onto raw line 55: while it is high, raw bit 55 reads 1 even if request line 55 is low.
- R3: A write to offset 0x200, 0x240, 0x600 or 0x640 loads the whole 64-bit mask of processor 0, 1, 2 or 3 respectively; a read of the same offset returns it.
- R4: Output `cpu_irq[i]` is registered and, from the clock edge after any request, cascade or mask change, is 1 exactly when the AND of mask i and the new raw value is nonzero.
- R5: A read of offset 0x280, 0x2C0, 0x680 or 0x6C0 returns mask AND raw for processor 0, 1, 2 or 3.
- R6: Writes to the raw offset or to any view offset change no state and raise no error.
- R7: A processor whose bit in `CPU_PRESENT` is 0 never asserts its output; its mask and view stay readable.
- R8: A read of an undecoded offset returns all ones with `reg_err` high; a write to one raises `reg_err` and changes no mask.
- R9: After reset all masks and the raw register are zero, all outputs are low and `reg_rdata` is zero; read data and `reg_err` appear one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 64 | Level device request lines |
| cascade_in | input | 1 | Level request from the cascaded legacy controller |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| reg_err | output | 1 | One-cycle pulse for an undecoded access |
| cpu_irq | output | 4 | Hard-interrupt request per processor |

## Verification
The routing is driven with single-bit requests at both ends of the vector (bit 0, bit 63) and in the middle, so a swapped or truncated mask per processor shows up as the wrong output bit. Complementary dense patterns on the raw register separate a stuck or inverted raw bit from a correct capture, and the cascade pin is exercised alone so its OR onto line 55 is not hidden by the ordinary request. Mask rewrites that remove the only matching bit show that outputs fall as well as rise, and one absent slot with an all-ones mask tells gating of the output apart from gating of the readable view.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int RAW_OFFSET  = 'h300;
  localparam int VIEW_OFFSET = 'h80;

  // Mask offsets: pairs of processors share a 0x400-spaced page, 0x40 apart.
  function automatic int mask_offset(input int idx);
    return 'h200 + (idx / 2) * 'h400 + (idx % 2) * 'h40;
  endfunction

  function automatic int view_offset(input int idx);
    return mask_offset(idx) + VIEW_OFFSET;
  endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
  parameter int N_LINES      = 64,
  parameter int CASCADE_LINE = 55
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic               cascade_in,
  output logic [N_LINES-1:0] raw_nxt,
  output logic [N_LINES-1:0] raw_q
);

  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASCADE_LINE;

  always_comb begin
    raw_nxt = req_in;
    raw_nxt[CASCADE_LINE] = req_in[CASCADE_LINE] | cascade_in;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_nxt;
  end

  // R1: non-cascade bits follow the request pins one edge later
  p_raw_track_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((raw_q & ~CASC_BIT) == ($past(req_in) & ~CASC_BIT)));

  // R2: cascade pin forces its raw line
  p_cascade_line_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cascade_in)) |-> raw_q[CASCADE_LINE]);

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_router_pkg::*;
#(
  parameter int   N_LINES = 64,
  parameter int   ADDR_W  = 12,
  parameter int   IDX     = 0,
  parameter logic PRESENT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wdata,
  input  logic [N_LINES-1:0] raw_nxt,
  input  logic [N_LINES-1:0] raw_q,
  output logic [N_LINES-1:0] mask_q,
  output logic [N_LINES-1:0] view,
  output logic               irq_q
);

  localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(mask_offset(IDX));

  logic               hit;
  logic [N_LINES-1:0] mask_nxt;

  assign hit      = wr && (addr == MY_OFF);
  assign mask_nxt = hit ? wdata : mask_q;
  assign view     = mask_q & raw_q;

  // Output is computed from the next-state values so it lags any change by one edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      irq_q  <= PRESENT && (|(mask_nxt & raw_nxt));
    end
  end

  // R6 / R8: only a write to this bank's own offset moves the mask
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == MY_OFF) |=> $stable(mask_q));

  // R3: a write to this offset lands in the mask
  p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == MY_OFF) |=> (mask_q == $past(wdata)));

  // R4: registered output agrees with the stored mask and raw state
  p_irq_level_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_q == (PRESENT && (|(mask_q & raw_q)))));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_router_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int N_CPU   = 4,
  parameter int ADDR_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [N_LINES-1:0]            raw_q,
  input  logic [N_CPU-1:0][N_LINES-1:0] masks,
  input  logic [N_CPU-1:0][N_LINES-1:0] views,
  output logic [N_LINES-1:0]            rdata,
  output logic                          err
);

  logic               hit;
  logic [N_LINES-1:0] sel;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    if (addr == ADDR_W'(RAW_OFFSET)) begin
      hit = 1'b1;
      sel = raw_q;
    end
    for (int i = 0; i < N_CPU; i++) begin
      if (addr == ADDR_W'(mask_offset(i))) begin
        hit = 1'b1;
        sel = masks[i];
      end
      if (addr == ADDR_W'(view_offset(i))) begin
        hit = 1'b1;
        sel = views[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= (rd || wr) && !hit;
      if (rd) rdata <= hit ? sel : '1;
    end
  end

  // R8: undecoded read yields all ones and an error pulse
  p_unmapped_rd_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit) |=> (err && (&rdata)));

  // R6: decoded accesses never flag an error
  p_mapped_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ((rd || wr) && hit) |=> !err);

  // R9: no strobe, no error
  p_idle_no_err_r9: assert property (@(posedge clk) disable iff (rst)
    !(rd || wr) |=> !err);

endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int             N_LINES      = 64,
  parameter int             N_CPU        = 4,
  parameter int             ADDR_W       = 12,
  parameter int             CASCADE_LINE = 55,
  parameter logic [N_CPU-1:0] CPU_PRESENT = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic               cascade_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               reg_err,
  output logic [N_CPU-1:0]   cpu_irq
);

  logic [N_LINES-1:0]            raw_nxt;
  logic [N_LINES-1:0]            raw_q;
  logic [N_CPU-1:0][N_LINES-1:0] masks;
  logic [N_CPU-1:0][N_LINES-1:0] views;

  irq_raw_capture #(
    .N_LINES      (N_LINES),
    .CASCADE_LINE (CASCADE_LINE)
  ) u_raw (
    .clk        (clk),
    .rst        (rst),
    .req_in     (req_in),
    .cascade_in (cascade_in),
    .raw_nxt    (raw_nxt),
    .raw_q      (raw_q)
  );

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    irq_mask_bank #(
      .N_LINES (N_LINES),
      .ADDR_W  (ADDR_W),
      .IDX     (g),
      .PRESENT (CPU_PRESENT[g])
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .raw_nxt (raw_nxt),
      .raw_q   (raw_q),
      .mask_q  (masks[g]),
      .view    (views[g]),
      .irq_q   (cpu_irq[g])
    );
  end

  irq_reg_port #(
    .N_LINES (N_LINES),
    .N_CPU   (N_CPU),
    .ADDR_W  (ADDR_W)
  ) u_port (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .raw_q (raw_q),
    .masks (masks),
    .views (views),
    .rdata (reg_rdata),
    .err   (reg_err)
  );

  // R7: absent slots stay silent
  p_absent_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq & ~CPU_PRESENT) == '0);

  // R9: outputs are low during the cycle after reset
  p_reset_low_r9: assert property (@(posedge clk)
    $past(rst) |-> (cpu_irq == '0));

endmodule

// File: tb/irq_router_test.sv
module irq_router_test;

  localparam int CLK_P = 10;
  localparam logic [3:0] PRES = 4'b1011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] req_in = '0;
  logic        cascade_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        reg_err;
  logic [3:0]  cpu_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_router #(.CPU_PRESENT(PRES)) uut (
    .clk(clk), .rst(rst), .req_in(req_in), .cascade_in(cascade_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .cpu_irq(cpu_irq)
  );

  localparam logic [11:0] MOFF [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
  localparam logic [11:0] VOFF [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};
  localparam logic [11:0] RAWOFF = 12'h300;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [63:0] d, output logic e);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    e = reg_err;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [63:0] d, output logic e);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; e = reg_err;
  endtask

  task automatic set_req(input logic [63:0] r, input logic c);
    @(negedge clk);
    req_in = r; cascade_in = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [63:0] d; logic e;
    chk("R9 irq after reset", 64'(cpu_irq), 64'h0);
    chk("R9 rdata after reset", reg_rdata, 64'h0);
    chk("R9 err after reset", 64'(reg_err), 64'h0);
    do_read(RAWOFF, d, e);
    chk("R9 raw after reset", d, 64'h0);
    for (int i = 0; i < 4; i++) begin
      do_read(MOFF[i], d, e);
      chk("R9 mask after reset", d, 64'h0);
    end
  endtask

  task automatic t_raw_track;
    logic [63:0] d; logic e;
    set_req(64'hA5C3_0F96_1234_5678, 1'b0);
    do_read(RAWOFF, d, e);
    chk("R1 raw pattern A", d, 64'hA5C3_0F96_1234_5678);
    set_req(~64'hA5C3_0F96_1234_5678, 1'b0);
    do_read(RAWOFF, d, e);
    chk("R1 raw pattern ~A", d, ~64'hA5C3_0F96_1234_5678);
    chk("R1 raw read no err", 64'(e), 64'h0);
    set_req(64'h0, 1'b0);
    do_read(RAWOFF, d, e);
    chk("R1 raw cleared", d, 64'h0);
  endtask

  task automatic t_mask_rw;
    logic [63:0] d; logic e;
    logic [63:0] pat [4];
    pat = '{64'h1111_2222_3333_4444, 64'h8000_0000_0000_0001,
            64'hFFFF_0000_FFFF_0000, 64'h0F0F_F0F0_0F0F_F0F0};
    for (int i = 0; i < 4; i++) do_write(MOFF[i], pat[i], e);
    for (int i = 0; i < 4; i++) begin
      do_read(MOFF[i], d, e);
      chk("R3 mask readback", d, pat[i]);
    end
  endtask

  task automatic t_irq;
    logic e;
    do_write(MOFF[0], 64'h1, e);
    do_write(MOFF[1], 64'h8000_0000_0000_0000, e);
    do_write(MOFF[2], '1, e);
    do_write(MOFF[3], 64'h400, e);
    set_req(64'h0, 1'b0);
    chk("R4 no requests", 64'(cpu_irq), 64'h0);
    set_req(64'h1, 1'b0);
    chk("R4 bit0 to cpu0 (cpu2 absent)", 64'(cpu_irq), 64'b0001);
    set_req(64'h8000_0000_0000_0400, 1'b0);
    chk("R4 bit63 and bit10", 64'(cpu_irq), 64'b1010);
    do_write(MOFF[3], 64'h0, e);
    chk("R4 mask write lowers cpu3", 64'(cpu_irq), 64'b0010);
    do_write(MOFF[0], 64'h8000_0000_0000_0000, e);
    chk("R4 mask write raises cpu0", 64'(cpu_irq), 64'b0011);
  endtask

  task automatic t_view;
    logic [63:0] d; logic e;
    do_write(MOFF[0], 64'h00FF_00FF_00FF_00FF, e);
    do_write(MOFF[1], 64'hF000_0000_0000_000F, e);
    do_write(MOFF[2], '1, e);
    do_write(MOFF[3], 64'h0, e);
    set_req(64'h1234_5678_9ABC_DEF0, 1'b0);
    do_read(VOFF[0], d, e);
    chk("R5 view cpu0", d, 64'h0034_0078_00BC_00F0);
    do_read(VOFF[1], d, e);
    chk("R5 view cpu1", d, 64'h1000_0000_0000_0000);
    do_read(VOFF[2], d, e);
    chk("R7 view of absent cpu2 readable", d, 64'h1234_5678_9ABC_DEF0);
    do_read(VOFF[3], d, e);
    chk("R5 view cpu3 empty", d, 64'h0);
  endtask

  task automatic t_absent;
    chk("R7 absent cpu2 stays low", 64'(cpu_irq[2]), 64'h0);
    set_req('1, 1'b1);
    chk("R7 all lines, cpu2 low", 64'(cpu_irq), 64'b0011);
  endtask

  task automatic t_cascade;
    logic [63:0] d; logic e;
    do_write(MOFF[0], 64'h0080_0000_0000_0000, e);
    do_write(MOFF[1], 64'h0, e);
    set_req(64'h0, 1'b1);
    do_read(RAWOFF, d, e);
    chk("R2 cascade sets raw bit55", d, 64'h0080_0000_0000_0000);
    chk("R2 cascade routes to cpu0", 64'(cpu_irq), 64'b0001);
    set_req(64'h0, 1'b0);
    chk("R2 cascade low clears cpu0", 64'(cpu_irq), 64'b0000);
  endtask

  task automatic t_ro_write;
    logic [63:0] d; logic e;
    set_req(64'h0000_0000_0000_00F0, 1'b0);
    do_write(RAWOFF, '1, e);
    chk("R6 raw write no err", 64'(e), 64'h0);
    do_write(VOFF[0], '1, e);
    chk("R6 view write no err", 64'(e), 64'h0);
    do_read(RAWOFF, d, e);
    chk("R6 raw unchanged", d, 64'h0000_0000_0000_00F0);
    do_read(MOFF[0], d, e);
    chk("R6 mask unchanged", d, 64'h0080_0000_0000_0000);
    chk("R6 outputs unchanged", 64'(cpu_irq), 64'h0);
  endtask

  task automatic t_unmapped;
    logic [63:0] d; logic e;
    do_read(12'h100, d, e);
    chk("R8 unmapped read data", d, '1);
    chk("R8 unmapped read err", 64'(e), 64'h1);
    do_read(12'h204, d, e);
    chk("R8 near-mask read data", d, '1);
    do_write(12'h208, 64'h1, e);
    chk("R8 unmapped write err", 64'(e), 64'h1);
    for (int i = 0; i < 4; i++) begin
      do_write(MOFF[i] + 12'h8, '1, e);
    end
    do_read(MOFF[0], d, e);
    chk("R8 mask0 untouched", d, 64'h0080_0000_0000_0000);
    do_read(MOFF[1], d, e);
    chk("R8 mask1 untouched", d, 64'h0);
    @(negedge clk);
    chk("R9 err pulse is one cycle", 64'(reg_err), 64'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_raw_track();
    t_mask_rw();
    t_irq();
    t_view();
    t_absent();
    t_cascade();
    t_ro_write();
    t_unmapped();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule